// File: doc/BRIEF.md
# PMIC Bypass I2C Write Engine

This block sits inside a power manager and pushes single-byte register writes out to an external power-management IC on a private I2C channel. Software fills a 32-bit command word with the target's 7-bit address, the 8-bit register number and the 8-bit value. Setting the go bit in the same word launches exactly one write. The bus carries a START, the address byte with the write direction, the register byte, the data byte and a STOP.

The go bit doubles as a busy flag. Hardware drops it once the STOP has been sent, so software just polls the command word. A clock word sets the SCL high and low times in system-clock cycles. Hardware adds a fixed 5 cycles to the high count and 7 cycles to the low count, which makes a 40/60 duty at up to 400 kHz easy to program.

A missing acknowledge ends the write early with a STOP and latches an error flag that software clears. A mode word holds the channel option bits. With high-speed mode off, only the standard timing below is used. The bus pins are open-drain and are modelled as active-high pull-down enables, with an SDA input for sampling the acknowledge.

Top module: `pmic_wr_engine`

## Requirements
- R1: The command word at register index 0 holds the slave address in bits 6:0 and the register number in bits 15:8. It holds the data byte in bits 23:16 and the go/busy flag in bit 24. Bit 7 and bits 31:25 read as 0. Writing it with bit 24 clear loads the fields and starts no bus activity.
- R2: Writing the command word with bit 24 set, while idle, produces exactly one frame. The frame is a START (SDA falls while SCL is high), then {address, 0}, then the register byte, then the data byte, then a STOP (SDA rises while SCL is high). Bytes go MSB first, and each byte is followed by an acknowledge slot in which SDA is released. When idle, both pins are released.
- R3: Bit 24 of the command word reads 1 from the cycle after the launching write until the frame has ended with its STOP. It then reads 0.
- R4: The clock word at index 1 holds the high count H in bits 7:0 and the low count L in bits 15:8. Inside a frame, every SCL low period lasts L+7 system cycles and every SCL high period between two falling edges lasts H+5 cycles.
- R5: Inside a frame, SDA changes only while SCL is low, except for the START and STOP edges.
- R6: If SDA reads high in any acknowledge slot, the engine sends no further bytes and issues a STOP. Bit 24 then clears, and bit 0 of the status word at index 3 becomes 1. That flag stays 1 through later frames until software writes 1 to bit 0 of index 3.
- R7: A write to the command word while bit 24 reads 1 is ignored. The stored fields keep their values and no second frame follows.
- R8: The mode word at index 2 stores bits 1:0 (high-speed code), bit 3 (high-speed enable), bit 4 (voltage-loop enable) and bit 6 (input filter enable). All other bits read 0. The mode bits do not change the bus timing of R4.
- R9: After reset, all four register words read 0 and both pin enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 command, 1 clock, 2 mode, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the word selected by reg_addr (combinational) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled level of the SDA wire |

## Verification
The bench decodes the bus from the pin enables and a modelled slave. It compares every byte and acknowledge against a queue that the driver fills, so a design with a wrong bit order, a missing write-direction bit or an extra byte fails at the STOP. It measures every SCL level inside a frame. An engine that left out or doubled the +5/+7 offsets, or that let the high-speed bit alter timing, would show mismatched periods. The bench forces a NACK on the address, register and data bytes. It checks that the frame stops early and the busy bit clears, and that the error flag survives a later good frame. It also fires a second go write while a frame is running and checks that the stored fields and the frame count stay unchanged.

// File: rtl/pmic_wr_pkg.sv
package pmic_wr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_LOW,
      PH_HIGH,
      PH_STOP_LOW,
      PH_STOP_HIGH,
      PH_STOP_END
   } phase_e;

   localparam logic [1:0] RG_CMD  = 2'd0;
   localparam logic [1:0] RG_CLK  = 2'd1;
   localparam logic [1:0] RG_MODE = 2'd2;
   localparam logic [1:0] RG_STAT = 2'd3;

   localparam int         GO_BIT    = 24;
   localparam logic [7:0] MODE_MASK = 8'h5B;
   localparam int         NBYTE     = 3;
   localparam int         SLOT_W    = 9;

endpackage

// File: rtl/pmic_wr_regs.sv
module pmic_wr_regs
   import pmic_wr_pkg::*;
#(
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [1:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             xfer_done,
   input  logic             nack_evt,
   output logic             busy,
   output logic             go,
   output logic             err,
   output logic [6:0]       sa,
   output logic [7:0]       ra,
   output logic [7:0]       wd,
   output logic [CFG_W-1:0] hi_cfg,
   output logic [CFG_W-1:0] lo_cfg
);

   if (CFG_W < 1 || CFG_W > 8) begin : g_bad_cfg_w
      $error("pmic_wr_regs: CFG_W must lie in 1..8");
   end

   logic       valid_q;
   logic       go_q;
   logic       err_q;
   logic [7:0] mode_q;
   logic       unused_wdata;

   assign unused_wdata = ^reg_wdata[31:25];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         go_q    <= 1'b0;
         err_q   <= 1'b0;
         mode_q  <= '0;
         sa      <= '0;
         ra      <= '0;
         wd      <= '0;
         hi_cfg  <= '0;
         lo_cfg  <= '0;
      end else begin
         go_q <= 1'b0;
         if (reg_we) begin
            case (reg_addr)
               RG_CMD: begin
                  if (!valid_q) begin
                     sa      <= reg_wdata[6:0];
                     ra      <= reg_wdata[15:8];
                     wd      <= reg_wdata[23:16];
                     valid_q <= reg_wdata[GO_BIT];
                     go_q    <= reg_wdata[GO_BIT];
                  end
               end
               RG_CLK: begin
                  hi_cfg <= reg_wdata[CFG_W-1:0];
                  lo_cfg <= reg_wdata[8 +: CFG_W];
               end
               RG_MODE: mode_q <= reg_wdata[7:0] & MODE_MASK;
               default: begin
                  if (reg_wdata[0]) err_q <= 1'b0;
               end
            endcase
         end
         if (xfer_done) valid_q <= 1'b0;
         if (nack_evt)  err_q   <= 1'b1;
      end
   end

   assign busy = valid_q;
   assign go   = go_q;
   assign err  = err_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RG_CMD:  reg_rdata = {7'b0, valid_q, wd, ra, 1'b0, sa};
         RG_CLK: begin
            reg_rdata[CFG_W-1:0] = hi_cfg;
            reg_rdata[8 +: CFG_W] = lo_cfg;
         end
         RG_MODE: reg_rdata[7:0] = mode_q;
         default: reg_rdata[0]   = err_q;
      endcase
   end

endmodule

// File: rtl/pmic_wr_timer.sv
module pmic_wr_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= len - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/pmic_wr_bitseq.sv
module pmic_wr_bitseq
   import pmic_wr_pkg::*;
#(
   parameter int CFG_W  = 8,
   parameter int HI_OFS = 5,
   parameter int LO_OFS = 7,
   localparam int CNT_W = CFG_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [6:0]       sa,
   input  logic [7:0]       ra,
   input  logic [7:0]       wd,
   input  logic [CFG_W-1:0] hi_cfg,
   input  logic [CFG_W-1:0] lo_cfg,
   input  logic             expired,
   input  logic             sda_in,
   output logic             load,
   output logic [CNT_W-1:0] len,
   output phase_e           phase,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             done,
   output logic             nack_evt
);

   localparam int         FRAME_W  = NBYTE * SLOT_W;
   localparam logic [3:0] BIT_LAST = 4'(SLOT_W - 1);
   localparam logic [1:0] BYTE_END = 2'(NBYTE - 1);

   if (HI_OFS < 2 || LO_OFS < 2) begin : g_bad_ofs
      $error("pmic_wr_bitseq: offsets must be at least 2 cycles");
   end
   if (HI_OFS >= (1 << CFG_W) || LO_OFS >= (1 << CFG_W)) begin : g_big_ofs
      $error("pmic_wr_bitseq: offsets must fit in CFG_W bits");
   end

   phase_e             ph_q, ph_d;
   logic [FRAME_W-1:0] sh_q;
   logic [3:0]         bitpos_q;
   logic [1:0]         bytecnt_q;
   logic               sda_q;
   logic [CNT_W-1:0]   t_high, t_low;
   logic               ack_slot;

   assign t_high   = CNT_W'(hi_cfg) + CNT_W'(HI_OFS);
   assign t_low    = CNT_W'(lo_cfg) + CNT_W'(LO_OFS);
   assign ack_slot = (bitpos_q == BIT_LAST);

   always_comb begin
      ph_d = ph_q;
      load = 1'b0;
      len  = t_high;
      case (ph_q)
         PH_IDLE: if (go) begin
            ph_d = PH_START;
            load = 1'b1;
         end
         PH_START: if (expired) begin
            ph_d = PH_LOW;
            load = 1'b1;
            len  = t_low;
         end
         PH_LOW: if (expired) begin
            ph_d = PH_HIGH;
            load = 1'b1;
         end
         PH_HIGH: if (expired) begin
            load = 1'b1;
            len  = t_low;
            if (ack_slot && (sda_in || bytecnt_q == BYTE_END)) ph_d = PH_STOP_LOW;
            else ph_d = PH_LOW;
         end
         PH_STOP_LOW: if (expired) begin
            ph_d = PH_STOP_HIGH;
            load = 1'b1;
         end
         PH_STOP_HIGH: if (expired) begin
            ph_d = PH_STOP_END;
            load = 1'b1;
         end
         PH_STOP_END: if (expired) ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_IDLE;
         sh_q      <= '0;
         bitpos_q  <= '0;
         bytecnt_q <= '0;
         sda_q     <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (ph_q == PH_IDLE && go) begin
            sh_q      <= {sa, 1'b0, 1'b1, ra, 1'b1, wd, 1'b1};
            bitpos_q  <= '0;
            bytecnt_q <= '0;
         end else if (ph_q == PH_HIGH && expired) begin
            sh_q <= {sh_q[FRAME_W-2:0], 1'b1};
            if (ack_slot) begin
               bitpos_q  <= '0;
               bytecnt_q <= bytecnt_q + 2'd1;
            end else begin
               bitpos_q <= bitpos_q + 4'd1;
            end
         end
         case (ph_q)
            PH_IDLE, PH_STOP_END:  sda_q <= 1'b0;
            PH_START, PH_STOP_LOW: sda_q <= 1'b1;
            PH_LOW:                sda_q <= ~sh_q[FRAME_W-1];
            default:               sda_q <= sda_q;
         endcase
      end
   end

   assign phase    = ph_q;
   assign scl_oe   = (ph_q == PH_LOW) || (ph_q == PH_STOP_LOW);
   assign sda_oe   = sda_q;
   assign done     = (ph_q == PH_STOP_END) && expired;
   assign nack_evt = (ph_q == PH_HIGH) && expired && ack_slot && sda_in;

endmodule

// File: rtl/pmic_wr_engine.sv
module pmic_wr_engine
   import pmic_wr_pkg::*;
#(
   parameter int CFG_W  = 8,
   parameter int HI_OFS = 5,
   parameter int LO_OFS = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        scl_oe,
   output logic        sda_oe,
   input  logic        sda_in
);

   localparam int CNT_W = CFG_W + 1;

   logic             busy, go, err_flag, xfer_done, nack_evt;
   logic             t_load, t_expired;
   logic [CNT_W-1:0] t_len;
   logic [6:0]       cmd_sa;
   logic [7:0]       cmd_ra, cmd_wd;
   logic [CFG_W-1:0] hi_cfg, lo_cfg;
   phase_e           phase;

   pmic_wr_regs #(.CFG_W(CFG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .xfer_done (xfer_done),
      .nack_evt  (nack_evt),
      .busy      (busy),
      .go        (go),
      .err       (err_flag),
      .sa        (cmd_sa),
      .ra        (cmd_ra),
      .wd        (cmd_wd),
      .hi_cfg    (hi_cfg),
      .lo_cfg    (lo_cfg)
   );

   pmic_wr_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load),
      .len     (t_len),
      .expired (t_expired)
   );

   pmic_wr_bitseq #(.CFG_W(CFG_W), .HI_OFS(HI_OFS), .LO_OFS(LO_OFS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .sa       (cmd_sa),
      .ra       (cmd_ra),
      .wd       (cmd_wd),
      .hi_cfg   (hi_cfg),
      .lo_cfg   (lo_cfg),
      .expired  (t_expired),
      .sda_in   (sda_in),
      .load     (t_load),
      .len      (t_len),
      .phase    (phase),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe),
      .done     (xfer_done),
      .nack_evt (nack_evt)
   );

endmodule

// File: rtl/pmic_wr_engine_chk.sv
module pmic_wr_engine_chk
   import pmic_wr_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic        scl_oe,
   input logic        sda_oe,
   input phase_e      phase,
   input logic        busy,
   input logic        err,
   input logic [6:0]  sa,
   input logic [7:0]  ra,
   input logic [7:0]  wd
);

   p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> (!scl_oe && !sda_oe));

   p_busy_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |-> busy);

   p_sda_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HIGH && $past(phase) == PH_HIGH) |-> $stable(sda_oe));

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(reg_we && reg_addr == RG_STAT && reg_wdata[0])) |=> err);

   p_cmd_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && reg_addr == RG_CMD) |=> $stable({sa, ra, wd}));

endmodule

bind pmic_wr_engine pmic_wr_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .phase     (phase),
   .busy      (busy),
   .err       (err_flag),
   .sa        (cmd_sa),
   .ra        (cmd_ra),
   .wd        (cmd_wd)
);

// File: tb/pmic_wr_engine_bench.sv
`timescale 1ns/1ps
module pmic_wr_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        scl_oe, sda_oe, sda_in;
   logic        slave_drive = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_in = ~(sda_oe | slave_drive);

   pmic_wr_engine u_pmic_wr_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe),
      .sda_in    (sda_in)
   );

   int total = 0;
   int bad   = 0;
   int cur_hi = 0, cur_lo = 0;
   int nack_sel = -1;
   int frames = 0;
   int sbad = 0;
   logic [8:0] exp_q[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: decodes the bus and compares against the scoreboard queue
   bit         scl_p = 1'b1, sda_p = 1'b1, in_frame = 1'b0, rose_seen = 1'b0;
   int         bitcnt = 0, byte_idx = 0, lvl_len = 0, tbad = 0;
   logic [7:0] shreg = '0;

   always @(negedge clk) begin
      bit         scl, sda;
      logic [8:0] item;
      scl = !scl_oe;
      sda = !(sda_oe || slave_drive);
      if (rst_n) begin
         if (scl && scl_p && sda_p && !sda) begin
            if (in_frame) sbad++;
            in_frame  = 1'b1;
            rose_seen = 1'b0;
            bitcnt    = 0;
            byte_idx  = 0;
            tbad      = 0;
         end else if (scl && scl_p && !sda_p && sda && in_frame) begin
            chk(tbad == 0, "R4 SCL period mismatches in frame", tbad, 0);
            chk(exp_q.size() == 0, "R2 bytes left unsent at STOP", exp_q.size(), 0);
            frames++;
            in_frame = 1'b0;
         end
         if (scl != scl_p) begin
            if (in_frame) begin
               if (scl) begin
                  if (lvl_len != cur_lo + 7) tbad++;
                  rose_seen = 1'b1;
                  if (bitcnt < 8) begin
                     shreg  = {shreg[6:0], sda};
                     bitcnt = bitcnt + 1;
                  end else begin
                     if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected byte", {23'b0, shreg, !sda}, 0);
                     end else begin
                        item = exp_q.pop_front();
                        chk({shreg, !sda} == item, "R2/R6 byte and ack", {shreg, !sda}, item);
                     end
                     bitcnt   = 0;
                     byte_idx = byte_idx + 1;
                  end
               end else begin
                  if (rose_seen && lvl_len != cur_hi + 5) tbad++;
                  if (bitcnt == 8) slave_drive = (byte_idx != nack_sel);
                  else if (bitcnt == 0) slave_drive = 1'b0;
               end
            end
            lvl_len = 1;
         end else begin
            lvl_len = lvl_len + 1;
         end
      end
      scl_p = scl;
      sda_p = sda;
   end

   // driver tasks
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 2'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic launch(input logic [6:0] sa, input logic [7:0] ra, input logic [7:0] dv, input int nb);
      logic [7:0] bytes [3];
      bytes[0] = {sa, 1'b0}; bytes[1] = ra; bytes[2] = dv;
      for (int b = 0; b < 3; b++) begin
         exp_q.push_back({bytes[b], b != nb});
         if (b == nb) break;
      end
      nack_sel = nb;
      wr(2'd0, {7'b0, 1'b1, dv, ra, 1'b0, sa});
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      do rd(2'd0, v); while (v[24]);
   endtask

   task automatic xfer(input logic [6:0] sa, input logic [7:0] ra, input logic [7:0] dv, input int nb);
      logic [31:0] v;
      int f0;
      f0 = frames;
      launch(sa, ra, dv, nb);
      rd(2'd0, v);
      chk(v[24] == 1'b1, "R3 busy bit set during frame", v, 32'h0100_0000);
      wait_idle();
      chk(frames == f0 + 1, "R3 busy cleared only after one STOP", frames, f0 + 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 0, "R9 register reads 0 after reset", v, 0);
      end
      chk({scl_oe, sda_oe} == 2'b00, "R9 pins released after reset", {scl_oe, sda_oe}, 0);

      // R1 field layout, masking, no start without go bit
      wr(2'd0, 32'hFEC3_5AFF);
      rd(2'd0, v);
      chk(v == 32'h00C3_5A7F, "R1 command fields", v, 32'h00C3_5A7F);
      wr(2'd0, 32'h00C3_5AFF);
      repeat (50) @(negedge clk);
      chk(frames == 0, "R1 no frame without go bit", frames, 0);

      // R4 clock word
      cur_hi = 3; cur_lo = 5;
      wr(2'd1, 32'h0000_0503);
      rd(2'd1, v);
      chk(v == 32'h0000_0503, "R4 clock word readback", v, 32'h0503);

      // R8 mode word masking, high-speed bit set during transfer
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, v);
      chk(v == 32'h0000_005B, "R8 mode word masking", v, 32'h5B);

      // R2 R4 R8 basic frame with mode bits set
      xfer(7'h12, 8'h55, 8'hA7, -1);
      wr(2'd2, 32'h0);

      // R4 different timing, R2 patterns
      cur_hi = 10; cur_lo = 20;
      wr(2'd1, 32'h0000_140A);
      xfer(7'h60, 8'h5B, 8'h3C, -1);
      xfer(7'h7F, 8'hFF, 8'h00, -1);
      rd(2'd3, v);
      chk(v == 0, "R6 no error after acked frames", v, 0);

      // R6 NACK on register byte
      cur_hi = 3; cur_lo = 5;
      wr(2'd1, 32'h0000_0503);
      xfer(7'h12, 8'h56, 8'h11, 1);
      rd(2'd3, v);
      chk(v == 1, "R6 error set after register NACK", v, 1);
      xfer(7'h2B, 8'h01, 8'h80, -1);
      rd(2'd3, v);
      chk(v == 1, "R6 error sticky through good frame", v, 1);
      wr(2'd3, 32'h1);
      rd(2'd3, v);
      chk(v == 0, "R6 error cleared by writing 1", v, 0);

      // R6 NACK on address and data bytes
      xfer(7'h33, 8'h44, 8'h55, 0);
      rd(2'd3, v);
      chk(v == 1, "R6 error after address NACK", v, 1);
      wr(2'd3, 32'h1);
      xfer(7'h0C, 8'hE1, 8'h9D, 2);
      rd(2'd3, v);
      chk(v == 1, "R6 error after data NACK", v, 1);
      wr(2'd3, 32'h1);

      // R7 write while busy is ignored
      begin
         int f0;
         f0 = frames;
         launch(7'h21, 8'h44, 8'h99, -1);
         repeat (20) @(negedge clk);
         wr(2'd0, 32'h01AA_BB0C);
         wait_idle();
         rd(2'd0, v);
         chk(v == 32'h0099_4421, "R7 fields unchanged by busy write", v, 32'h0099_4421);
         repeat (300) @(negedge clk);
         chk(frames == f0 + 1, "R7 no second frame", frames, f0 + 1);
      end

      chk(sbad == 0, "R5 SDA moved while SCL high inside frame", sbad, 0);
      chk({scl_oe, sda_oe} == 2'b00, "R2 pins released when idle", {scl_oe, sda_oe}, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule